// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller with Hold Wake-Up

This block collects interrupt events from five sources for a small microcontroller core and turns them into one request with a vector address. There are four internal timing sources: divider 0, divider 1, timer 0 and timer 1. The fifth source is an external pin that signals a port change. Each source keeps a pending flag that hardware sets. Each source also has a bit in each of two enable registers that software writes. A global enable sits above all of them. A request reaches the core only when a flag, both of its enable bits and the global enable are all set.

When the core takes the request, the controller clears the flag of the source it serviced and drops the global enable. Software turns the global enable back on with an explicit enable command or with a write to the first enable register. The controller also tracks a low-power hold state. A serviced interrupt wakes the core from hold. When the handler returns, the core goes back into hold.

Top module: `irq_vector_ctrl`

## Requirements
- R1: A one-cycle high on `src_evt_i[k]` sets the pending flag of source k. The mapping is bit 0 divider 0, bit 1 divider 1, bit 2 timer 0 and bit 3 timer 1. The external source uses index 4. A flag stays set until that source is serviced.
- R2: `irq_vec_o` shows the vector of the highest-priority source that is both pending and enabled. Priority runs from index 0 (highest) to index 4 (lowest). The vectors are 0x04, 0x08, 0x0C and 0x10 for indices 0 to 3, and 0x20 for index 4.
- R3: `irq_req_o` is high exactly when some source has its flag set, its bit set in `en_a_data_i`/`en_b_data_i` (bit k is source k) and the global enable set. The enable registers are loaded by `en_a_we_i` and `en_b_we_i`.
- R4: Acknowledging a raised request clears the serviced flag and the global enable, so `irq_req_o` is low on the next cycle. Other flags stay pending. The global enable is set again by `gie_set_i` or by a write to enable register A.
- R5: `gie_clr_i` clears the global enable, so no request follows. If `gie_clr_i` arrives in the same cycle as `gie_set_i` or an enable-register-A write, the clear wins.
- R6: `hold_req_i` puts the block in hold (`hold_o` = 1). An acknowledged interrupt in hold drops `hold_o` on the next cycle.
- R7: A `ret_i` after a hold wake restores `hold_o` = 1 on the next cycle. A `ret_i` with no pending wake leaves `hold_o` unchanged.
- R8: An event in the same cycle as an acknowledge is never lost. This holds whether the event comes from another source or from the source being serviced.
- R9: The external pin passes through a two-flip-flop synchroniser. Only a high-to-low transition sets flag 4. A rising transition sets nothing.
- R10: After reset, all flags, enables, the global enable and the hold state are clear: `irq_req_o` = 0 and `hold_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_evt_i | input | 4 | Internal event pulses (div0, div1, tmr0, tmr1) |
| port_pin_i | input | 1 | Asynchronous external port-change pin |
| en_a_we_i | input | 1 | Write strobe for enable register A; also sets the global enable |
| en_a_data_i | input | 5 | Data for enable register A |
| en_b_we_i | input | 1 | Write strobe for enable register B |
| en_b_data_i | input | 5 | Data for enable register B |
| gie_set_i | input | 1 | Global enable command |
| gie_clr_i | input | 1 | Global disable command |
| irq_req_o | output | 1 | Interrupt request to the core |
| irq_vec_o | output | 6 | Vector address of the granted source |
| irq_ack_i | input | 1 | Core accepts the request |
| hold_req_i | input | 1 | Core enters hold |
| ret_i | input | 1 | Handler return executed |
| hold_o | output | 1 | Core is held |

## Verification
The priority logic is swept over all 31 non-empty sets of pending sources. Each set is serviced to empty, and the bench checks the vector order against the lowest-set-bit rule, which separates a correct priority from a reversed or shifted one. A second sweep covers all 1024 pairs of enable-register values while all flags are pending. This sweep can tell a two-register AND from an OR or from a single-register test. Directed sequences cover:
- an event arriving on the same cycle as an acknowledge;
- enable and disable arriving together;
- a rising pin edge against a falling pin edge;
- a hold wake followed by a return, and a return with no wake.

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int NSRC  = 5,
  parameter int VEC_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-2:0]  src_evt_i,
  input  logic             port_pin_i,
  input  logic             en_a_we_i,
  input  logic [NSRC-1:0]  en_a_data_i,
  input  logic             en_b_we_i,
  input  logic [NSRC-1:0]  en_b_data_i,
  input  logic             gie_set_i,
  input  logic             gie_clr_i,
  output logic             irq_req_o,
  output logic [VEC_W-1:0] irq_vec_o,
  input  logic             irq_ack_i,
  input  logic             hold_req_i,
  input  logic             ret_i,
  output logic             hold_o
);
  logic [NSRC-1:0] flag_q, ena_q, enb_q, pend, sel;
  logic [2:0]      pin_q;
  logic            gie_q, hold_q, resume_q, take, ext_fall;

  assign ext_fall  = pin_q[2] & ~pin_q[1];
  assign pend      = flag_q & ena_q & enb_q;
  assign sel       = pend & (~pend + 1'b1);
  assign irq_req_o = gie_q & (|pend);
  assign take      = irq_ack_i & irq_req_o;
  assign hold_o    = hold_q;

  always_comb begin
    irq_vec_o = '0;
    for (int k = NSRC - 1; k >= 0; k--)
      if (pend[k]) irq_vec_o = (k == NSRC - 1) ? VEC_W'(32) : VEC_W'((k + 1) * 4);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q    <= '1;
      flag_q   <= '0;
      ena_q    <= '0;
      enb_q    <= '0;
      gie_q    <= 1'b0;
      hold_q   <= 1'b0;
      resume_q <= 1'b0;
    end else begin
      pin_q  <= {pin_q[1:0], port_pin_i};
      flag_q <= (flag_q & ~(take ? sel : '0)) | {ext_fall, src_evt_i};
      if (en_a_we_i) ena_q <= en_a_data_i;
      if (en_b_we_i) enb_q <= en_b_data_i;
      if (gie_clr_i || take)           gie_q <= 1'b0;
      else if (gie_set_i || en_a_we_i) gie_q <= 1'b1;
      if (take) begin
        hold_q   <= 1'b0;
        resume_q <= resume_q | hold_q;
      end else if (ret_i && resume_q) begin
        hold_q   <= 1'b1;
        resume_q <= 1'b0;
      end else if (hold_req_i) begin
        hold_q   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk #(
  parameter int VEC_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq_req_o,
  input logic [VEC_W-1:0] irq_vec_o,
  input logic             irq_ack_i,
  input logic             gie_clr_i,
  input logic             ret_i,
  input logic             hold_o,
  input logic             resume_q
);
  p_vec_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req_o |-> (irq_vec_o == 6'h04 || irq_vec_o == 6'h08 || irq_vec_o == 6'h0C ||
                   irq_vec_o == 6'h10 || irq_vec_o == 6'h20));

  p_ack_masks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack_i && irq_req_o) |=> !irq_req_o);

  p_disable_masks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    gie_clr_i |=> !irq_req_o);

  p_wake_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack_i && irq_req_o && hold_o) |=> !hold_o);

  p_rehold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && resume_q && !(irq_ack_i && irq_req_o)) |=> hold_o);

  p_no_req_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    resume_q |-> !hold_o);
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(.VEC_W(VEC_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .irq_req_o(irq_req_o), .irq_vec_o(irq_vec_o),
  .irq_ack_i(irq_ack_i), .gie_clr_i(gie_clr_i), .ret_i(ret_i),
  .hold_o(hold_o), .resume_q(resume_q)
);

// File: tb/irq_vector_ctrl_tb.sv
module irq_vector_ctrl_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] src_evt = '0;
  logic pin = 1'b1, a_we = 1'b0, b_we = 1'b0, gset = 1'b0, gclr = 1'b0;
  logic [4:0] a_d = '0, b_d = '0;
  logic req, ack = 1'b0, hreq = 1'b0, ret = 1'b0, hold;
  logic [5:0] vec;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_vector_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .src_evt_i(src_evt), .port_pin_i(pin),
    .en_a_we_i(a_we), .en_a_data_i(a_d), .en_b_we_i(b_we), .en_b_data_i(b_d),
    .gie_set_i(gset), .gie_clr_i(gclr), .irq_req_o(req), .irq_vec_o(vec),
    .irq_ack_i(ack), .hold_req_i(hreq), .ret_i(ret), .hold_o(hold)
  );

  function automatic int vec_of(int idx);
    return (idx == 4) ? 32 : (idx + 1) * 4;
  endfunction

  function automatic int low_idx(int m);
    for (int k = 0; k < 5; k++) if (m[k]) return k;
    return -1;
  endfunction

  task automatic chk(bit ok, string r, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic pulse_evt(logic [3:0] m);
    src_evt = m; tick(); src_evt = '0;
  endtask

  task automatic ext_fall();
    pin = 1'b0; repeat (4) tick();
    pin = 1'b1; repeat (4) tick();
  endtask

  task automatic do_ack();
    ack = 1'b1; tick(); ack = 1'b0;
  endtask

  task automatic do_gset();
    gset = 1'b1; tick(); gset = 1'b0;
  endtask

  task automatic write_en(logic [4:0] a, logic [4:0] b);
    a_we = 1'b1; b_we = 1'b1; a_d = a; b_d = b; tick(); a_we = 1'b0; b_we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int rem, idx, pr;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    chk(req == 1'b0, "R10 req", req, 0);
    chk(hold == 1'b0, "R10 hold", hold, 0);

    // R1/R2/R4: priority sweep over every non-empty pending set
    write_en(5'h1F, 5'h1F);
    for (int p = 1; p < 32; p++) begin
      if (p[3:0] != 0) pulse_evt(p[3:0]);
      if (p[4]) ext_fall();
      do_gset();
      rem = p;
      while (rem != 0) begin
        idx = low_idx(rem);
        chk(req == 1'b1, "R1 req pending", req, 1);
        chk(vec == vec_of(idx), "R2 vector", vec, vec_of(idx));
        do_ack();
        rem &= ~(1 << idx);
        chk(req == 1'b0, "R4 masked after ack", req, 0);
        do_gset();
      end
      chk(req == 1'b0, "R4 flags cleared", req, 0);
    end

    // R3: sweep all enable pairs with every flag pending
    write_en(5'h00, 5'h00);
    pulse_evt(4'hF);
    ext_fall();
    for (int a = 0; a < 32; a++) begin
      for (int b = 0; b < 32; b++) begin
        write_en(a[4:0], b[4:0]);
        pr = a & b;
        chk(req == (pr != 0), "R3 request gating", req, pr != 0);
        if (pr != 0) chk(vec == vec_of(low_idx(pr)), "R3 vector", vec, vec_of(low_idx(pr)));
      end
    end

    // R5: disable command, and disable beats enable
    write_en(5'h1F, 5'h1F);
    chk(req == 1'b1, "R5 pre", req, 1);
    gclr = 1'b1; tick(); gclr = 1'b0;
    chk(req == 1'b0, "R5 disable", req, 0);
    gclr = 1'b1; gset = 1'b1; tick(); gclr = 1'b0; gset = 1'b0;
    chk(req == 1'b0, "R5 clear wins", req, 0);
    gclr = 1'b1; a_we = 1'b1; a_d = 5'h1F; tick(); gclr = 1'b0; a_we = 1'b0;
    chk(req == 1'b0, "R5 clear wins over write", req, 0);

    // drain all flags
    do_gset();
    while (req) begin do_ack(); do_gset(); end

    // R4: enable register A write re-enables
    pulse_evt(4'b0110);
    do_ack();
    chk(req == 1'b0, "R4 masked", req, 0);
    a_we = 1'b1; a_d = 5'h1F; tick(); a_we = 1'b0;
    chk(req == 1'b1 && vec == 12, "R4 reenable by write", vec, 12);
    do_ack(); do_gset();
    chk(req == 1'b0, "R4 drained", req, 0);

    // R8: event during ack of another source, and of the same source
    pulse_evt(4'b0010);
    chk(vec == 8, "R8 pre", vec, 8);
    ack = 1'b1; src_evt = 4'b0001; tick(); ack = 1'b0; src_evt = '0;
    do_gset();
    chk(req == 1'b1 && vec == 4, "R8 other source kept", vec, 4);
    ack = 1'b1; src_evt = 4'b0001; tick(); ack = 1'b0; src_evt = '0;
    do_gset();
    chk(req == 1'b1 && vec == 4, "R8 same source kept", vec, 4);
    do_ack(); do_gset();
    chk(req == 1'b0, "R8 drained", req, 0);

    // R9: rising pin edge does nothing, falling edge sets flag 4
    pin = 1'b0; tick(); tick();
    repeat (3) tick();
    chk(req == 1'b1 && vec == 32, "R9 falling edge", vec, 32);
    do_ack(); do_gset();
    pin = 1'b1; repeat (5) tick();
    chk(req == 1'b0, "R9 rising ignored", req, 0);

    // R6/R7: hold wake and return
    ret = 1'b1; tick(); ret = 1'b0;
    chk(hold == 1'b0, "R7 ret without wake", hold, 0);
    hreq = 1'b1; tick(); hreq = 1'b0;
    chk(hold == 1'b1, "R6 enter hold", hold, 1);
    pulse_evt(4'b1000);
    chk(req == 1'b1 && vec == 16, "R6 request in hold", vec, 16);
    chk(hold == 1'b1, "R6 still held before ack", hold, 1);
    do_ack();
    chk(hold == 1'b0, "R6 woken", hold, 0);
    ret = 1'b1; tick(); ret = 1'b0;
    chk(hold == 1'b1, "R7 back to hold", hold, 1);
    ret = 1'b1; tick(); ret = 1'b0;
    chk(hold == 1'b1, "R7 second ret no change", hold, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule